// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital half of a successive-approximation converter. A one-cycle start request captures the configuration: resolution, sample-window length, tick source and tick divider. The block then closes the sample switch for a fixed number of conversion ticks. It opens the switch and resolves the result one bit per tick, most significant bit first. For each bit it drives a trial code to the DAC and reads back a single comparator decision. When the last bit is decided, the code is right-justified into the result register and a completion flag is raised.

Conversion ticks are single-cycle enables in the system clock domain. They come from one of four sources, and a counter divides them by 1, 2, 4 or 8. The asynchronous source needs a warm-up interval before its first sample. In continuous mode each completion starts the next sample window at once. A fresh start request at any time abandons the current conversion and begins again.

Top module: `sar_ctrl`

## Requirements
- R1: After reset `busy`, `sample_en` and `done_flag` are 0, and `dac_code` and `result` are all zeros.
- R2: A start request captured at a clock edge opens the sample window from that edge, except when the asynchronous source is selected. The window lasts 4 conversion ticks with `long_smp`=0 and 24 ticks with `long_smp`=1. Configuration inputs are captured with the start request.
- R3: Bits are resolved MSB first. Each trial bit is kept when `cmp_hi`=1 (input at or above the DAC level) and cleared otherwise. `res_mode` 00 gives 8 bits, 01 gives 10 bits, and 10 or 11 give 12 bits. The result is the floor of the input code at that resolution, right-justified in `result`, and the trial code sits left-aligned in the 12-bit `dac_code`.
- R4: `done_flag` rises on the conversion tick that decides the last bit, which is tick number S+N after the start edge (S = window ticks, N = result bits).
- R5: `div_sel` 00, 01, 10, 11 divides the tick source by 1, 2, 4, 8. The divider restarts at the start edge, so with the bus source tick k falls on clock edge k·D after the start edge.
- R6: `clk_src` selects the tick source: 00 is the bus clock, 01 is the bus clock halved, 10 is `alt_tick` and 11 is `async_tick`. With 11, 10 warm-up ticks pass before the sample window of a started conversion.
- R7: `result` changes only at completion, which also sets `done_flag`. Otherwise `result` holds its value, including across later start requests.
- R8: `done_flag` clears on `rd_ack` or on a start request. A completion in the same cycle as `rd_ack` leaves the flag set.
- R9: With `cont`=1 the next sample window opens at the completing edge, with no warm-up, so completions are S+N ticks apart. Dropping `cont` lets the running conversion finish and then the block goes idle.
- R10: A start request while `busy` abandons the conversion without writing a result and restarts from the window (or warm-up). The next completion follows the same latency as a fresh start.
- R11: `sample_en` is high exactly during the sample window and implies `busy`. `dac_code` is zero outside the approximation phase, and the first trial after the window is 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle conversion request; captures configuration |
| cont | input | 1 | Continuous conversion enable |
| long_smp | input | 1 | 1 selects the 24-tick sample window, 0 the 4-tick one |
| res_mode | input | 2 | Resolution: 00 = 8, 01 = 10, 1x = 12 bits |
| clk_src | input | 2 | Tick source: bus, bus/2, alt, async |
| div_sel | input | 2 | Tick divider: 1, 2, 4, 8 |
| alt_tick | input | 1 | Alternate tick source enable |
| async_tick | input | 1 | Asynchronous-oscillator tick enable (already synchronised) |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| rd_ack | input | 1 | Result read strobe; clears the flag |
| dac_code | output | 12 | Left-aligned trial code to the DAC |
| sample_en | output | 1 | Sample switch closed |
| busy | output | 1 | Conversion (warm-up, sample or approximation) in progress |
| result | output | 12 | Right-justified conversion result |
| done_flag | output | 1 | Completion flag |

## Verification
The checker watches several rules on every cycle. The sample switch is closed only while busy, and the DAC stays quiet while it is closed. The first trial code is 0x800. The result changes only together with a raised flag, and a start or idle read always clears the flag. Whether each bit of a result is right, the exact tick counts of the window and of the latency under each resolution, divider and source, the spacing of continuous conversions, and the effect of an abort can only be shown by the bench's scenarios. There, a comparator model turns a known input code into decisions, and the cycle counts are measured.

// File: rtl/sar_pkg.sv
// Shared types for the SAR conversion sequencer.
// Assumes a single system clock; all ticks are enables in that domain.
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARM = 2'd1,
        PH_SMP  = 2'd2,
        PH_CONV = 2'd3
    } phase_t;

    // configuration captured with each start request
    typedef struct packed {
        logic [1:0] src;
        logic [1:0] div;
        logic [1:0] mode;
        logic       lng;
    } cfg_t;

    localparam logic [1:0] SRC_BUS   = 2'd0;
    localparam logic [1:0] SRC_HALF  = 2'd1;
    localparam logic [1:0] SRC_ALT   = 2'd2;
    localparam logic [1:0] SRC_ASYNC = 2'd3;

endpackage

// File: rtl/sar_tick_gen.sv
// Conversion tick generator: picks a tick source and divides it by
// 1, 2, 4 or 8. The output is a single-cycle enable.
// Assumes alt and async ticks arrive already synchronised to clk.
// Both the halving toggle and the divider restart on `restart`.
module sar_tick_gen
    import sar_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] src,
    input  logic [1:0] div,
    input  logic       alt_tick,
    input  logic       async_tick,
    output logic       ck_en
);

    logic             half_q;
    logic             src_tick;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;

    // bus/2 toggle, realigned at each start
    always_ff @(posedge clk) begin
        if (!rst_n || restart) half_q <= 1'b0;
        else                   half_q <= ~half_q;
    end

    // source multiplexer
    always_comb begin
        unique case (src)
            SRC_BUS:   src_tick = 1'b1;
            SRC_HALF:  src_tick = half_q;
            SRC_ALT:   src_tick = alt_tick;
            default:   src_tick = async_tick;
        endcase
    end

    // divide limit: 2**div - 1
    always_comb begin
        div_lim = DIV_W'((4'd1 << div) - 4'd1);
    end

    // divider counter, advancing on source ticks
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  div_cnt <= '0;
        else if (src_tick)      div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + 1'b1;
    end

    // one tick per full divider period
    assign ck_en = src_tick && (div_cnt == div_lim);

endmodule

// File: rtl/sar_seq.sv
// Phase sequencer: warm-up, sample window, then one approximation step
// per tick. Captures configuration on start and restarts on any start.
// Assumes RES_W is 12 so that the 8/10/12-bit modes are meaningful.
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int SHORT_SMP  = 4,
    parameter int LONG_SMP   = 24,
    parameter int ASYNC_WAIT = 10,
    parameter int CNT_W      = 5,
    parameter int STEP_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont,
    input  logic              ck_en,
    input  cfg_t              cfg_in,
    output cfg_t              cfg_q,
    output phase_t            phase,
    output logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] nbits,
    output logic              first_trial,
    output logic              bit_tick,
    output logic              bit_last
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] smp_lim;
    logic             tick;

    assign tick = ck_en && !start;

    // resolution and window length from the captured configuration
    always_comb begin
        unique case (cfg_q.mode)
            2'b00:   nbits = STEP_W'(RES_W - 4);
            2'b01:   nbits = STEP_W'(RES_W - 2);
            default: nbits = STEP_W'(RES_W);
        endcase
        smp_lim = cfg_q.lng ? CNT_W'(LONG_SMP - 1) : CNT_W'(SHORT_SMP - 1);
    end

    assign bit_last    = (step == nbits - 1'b1);
    assign first_trial = tick && (phase == PH_SMP) && (cnt == smp_lim);
    assign bit_tick    = tick && (phase == PH_CONV);

    // phase, counters and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            step  <= '0;
            cfg_q <= '0;
        end else if (start) begin
            cfg_q <= cfg_in;
            cnt   <= '0;
            step  <= '0;
            phase <= (cfg_in.src == SRC_ASYNC && ASYNC_WAIT > 0) ? PH_WARM : PH_SMP;
        end else if (ck_en) begin
            unique case (phase)
                PH_WARM: begin
                    if (cnt == CNT_W'(ASYNC_WAIT - 1)) begin
                        phase <= PH_SMP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SMP: begin
                    if (cnt == smp_lim) begin
                        phase <= PH_CONV;
                        cnt   <= '0;
                        step  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (bit_last) begin
                        phase <= cont ? PH_SMP : PH_IDLE;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register, result register and completion flag.
// Each bit is trial-set, then kept or cleared from the comparator decision.
// Assumes step/nbits come from sar_seq and stay stable within a conversion.
module sar_approx #(
    parameter int RES_W  = 12,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_ack,
    input  logic              first_trial,
    input  logic              bit_tick,
    input  logic              bit_last,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] nbits,
    input  logic              cmp_hi,
    output logic [RES_W-1:0]  sar,
    output logic [RES_W-1:0]  result,
    output logic              done
);

    localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] bit_m;
    logic [RES_W-1:0] nxt;
    logic [RES_W-1:0] aligned;

    // decide the current bit and place the next trial bit
    always_comb begin
        bit_m = MSB >> step;
        nxt   = cmp_hi ? sar : (sar & ~bit_m);
        if (!bit_last) nxt = nxt | (bit_m >> 1);
        aligned = nxt >> (STEP_W'(RES_W) - nbits);
    end

    // trial register, result transfer and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else if (start) begin
            sar  <= '0;
            done <= 1'b0;
        end else begin
            if (first_trial) begin
                sar <= MSB;
            end else if (bit_tick) begin
                sar <= bit_last ? '0 : nxt;
                if (bit_last) result <= aligned;
            end
            if (bit_tick && bit_last) done <= 1'b1;
            else if (rd_ack)          done <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_ctrl.sv
// Top of the SAR conversion sequencer: tick generator, phase sequencer
// and approximation register. Analog parts are external; cmp_hi must
// settle within one tick of a dac_code change.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int SHORT_SMP  = 4,
    parameter int LONG_SMP   = 24,
    parameter int ASYNC_WAIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cont,
    input  logic             long_smp,
    input  logic [1:0]       res_mode,
    input  logic [1:0]       clk_src,
    input  logic [1:0]       div_sel,
    input  logic             alt_tick,
    input  logic             async_tick,
    input  logic             cmp_hi,
    input  logic             rd_ack,
    output logic [RES_W-1:0] dac_code,
    output logic             sample_en,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             done_flag
);

    localparam int CNT_MAX = (LONG_SMP > ASYNC_WAIT) ? LONG_SMP : ASYNC_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int STEP_W  = $clog2(RES_W + 1);

    cfg_t              cfg_in;
    cfg_t              cfg_q;
    phase_t            phase;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] nbits;
    logic              ck_en;
    logic              first_trial;
    logic              bit_tick;
    logic              bit_last;

    assign cfg_in = '{src: clk_src, div: div_sel, mode: res_mode, lng: long_smp};

    sar_tick_gen #(.DIV_W(3)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start),
        .src        (cfg_q.src),
        .div        (cfg_q.div),
        .alt_tick   (alt_tick),
        .async_tick (async_tick),
        .ck_en      (ck_en)
    );

    sar_seq #(
        .RES_W      (RES_W),
        .SHORT_SMP  (SHORT_SMP),
        .LONG_SMP   (LONG_SMP),
        .ASYNC_WAIT (ASYNC_WAIT),
        .CNT_W      (CNT_W),
        .STEP_W     (STEP_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cont        (cont),
        .ck_en       (ck_en),
        .cfg_in      (cfg_in),
        .cfg_q       (cfg_q),
        .phase       (phase),
        .step        (step),
        .nbits       (nbits),
        .first_trial (first_trial),
        .bit_tick    (bit_tick),
        .bit_last    (bit_last)
    );

    sar_approx #(.RES_W(RES_W), .STEP_W(STEP_W)) u_sar (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rd_ack      (rd_ack),
        .first_trial (first_trial),
        .bit_tick    (bit_tick),
        .bit_last    (bit_last),
        .step        (step),
        .nbits       (nbits),
        .cmp_hi      (cmp_hi),
        .sar         (dac_code),
        .result      (result),
        .done        (done_flag)
    );

    assign sample_en = (phase == PH_SMP);
    assign busy      = (phase != PH_IDLE);

endmodule

// File: rtl/sar_ctrl_chk.sv
// Cycle-by-cycle protocol checks on the sequencer's ports, bound to sar_ctrl.
// Assumes the default 12-bit width.
module sar_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        rd_ack,
    input logic [1:0]  clk_src,
    input logic [11:0] dac_code,
    input logic        sample_en,
    input logic        busy,
    input logic [11:0] result,
    input logic        done_flag
);

    // R11: switch closed only inside a conversion
    p_smp_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> busy);

    // R11: DAC idle while sampling
    p_dac_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (dac_code == 12'h000));

    // R11: first trial code after the window is the MSB
    p_msb_trial_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_en) && busy && !$past(start)) |-> (dac_code == 12'h800));

    // R7: flag only rises at the end of a running conversion
    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy));

    // R7: result changes only together with the flag
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done_flag);

    // R8: start always clears the flag
    p_start_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_flag);

    // R8: read strobe while idle clears the flag
    p_ack_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !busy) |=> !done_flag);

    // R2: non-async start opens the window at once
    p_start_smp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clk_src != 2'b11) |=> sample_en);

    // R6: async start enters warm-up first
    p_start_warm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clk_src == 2'b11) |=> (busy && !sample_en));

endmodule

bind sar_ctrl sar_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_ack    (rd_ack),
    .clk_src   (clk_src),
    .dac_code  (dac_code),
    .sample_en (sample_en),
    .busy      (busy),
    .result    (result),
    .done_flag (done_flag)
);

// File: tb/sar_ctrl_test.sv
`timescale 1ns/1ps
module sar_ctrl_test;

    localparam int SHORT = 4;
    localparam int LONG  = 24;
    localparam int WARM  = 10;

    // {vin[16:5], mode[4:3], long[2], div[1:0]} with the bus source
    localparam logic [16:0] VEC [0:7] = '{
        {12'hABC, 2'd0, 1'b0, 2'd0},
        {12'hABC, 2'd1, 1'b0, 2'd0},
        {12'hABC, 2'd2, 1'b0, 2'd0},
        {12'hFFF, 2'd2, 1'b1, 2'd0},
        {12'h000, 2'd0, 1'b1, 2'd1},
        {12'h800, 2'd1, 1'b0, 2'd2},
        {12'h7FF, 2'd2, 1'b0, 2'd3},
        {12'h123, 2'd3, 1'b1, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic        long_smp = 1'b0;
    logic [1:0]  res_mode = 2'd0;
    logic [1:0]  clk_src = 2'd0;
    logic [1:0]  div_sel = 2'd0;
    logic        alt_tick = 1'b0;
    logic        async_tick = 1'b0;
    logic        rd_ack = 1'b0;
    logic        alt_run = 1'b0;
    logic [11:0] vin = 12'h000;
    logic        cmp_hi;
    logic [11:0] dac_code;
    logic        sample_en;
    logic        busy;
    logic [11:0] result;
    logic        done_flag;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    // comparator model: input at or above DAC level
    assign cmp_hi = (vin >= dac_code);

    // alternate source: a tick every second cycle
    always @(negedge clk) alt_tick <= alt_run ? ~alt_tick : 1'b0;

    sar_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cont       (cont),
        .long_smp   (long_smp),
        .res_mode   (res_mode),
        .clk_src    (clk_src),
        .div_sel    (div_sel),
        .alt_tick   (alt_tick),
        .async_tick (async_tick),
        .cmp_hi     (cmp_hi),
        .rd_ack     (rd_ack),
        .dac_code   (dac_code),
        .sample_en  (sample_en),
        .busy       (busy),
        .result     (result),
        .done_flag  (done_flag)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] m);
        return (m == 2'd0) ? 8 : (m == 2'd1) ? 10 : 12;
    endfunction

    function automatic logic [11:0] exp_res(input logic [11:0] v, input logic [1:0] m);
        return v >> (12 - nbits_of(m));
    endfunction

    // start one conversion, count negedges to the flag and window cycles
    task automatic run_one(input logic [11:0] v, input logic [1:0] m, input logic lg,
                           input logic [1:0] s, input logic [1:0] d,
                           output int lat, output int smp);
        @(negedge clk);
        vin = v; res_mode = m; long_smp = lg; clk_src = s; div_sel = d; start = 1'b1;
        lat = 0; smp = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (sample_en) smp++;
        end while (!done_flag && lat < 5000);
    endtask

    // count negedges to the next flag after clearing it with rd_ack
    task automatic next_done(output int gap);
        rd_ack = 1'b1;
        gap = 0;
        do begin
            @(negedge clk);
            rd_ack = 1'b0;
            gap++;
        end while (!done_flag && gap < 5000);
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int smp;
        int gap;
        logic [11:0] held;
        logic        early;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !sample_en && !done_flag, "R1 flags", {busy, sample_en, done_flag}, 0);
        check(dac_code == 0 && result == 0, "R1 data", result, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: vector table with the bus source
        for (int i = 0; i < 8; i++) begin
            logic [11:0] v;
            logic [1:0]  m;
            logic        lg;
            logic [1:0]  d;
            int          s_t;
            v  = VEC[i][16:5];
            m  = VEC[i][4:3];
            lg = VEC[i][2];
            d  = VEC[i][1:0];
            s_t = lg ? LONG : SHORT;
            run_one(v, m, lg, 2'd0, d, lat, smp);
            check(result == exp_res(v, m), "R3 result", result, exp_res(v, m));
            check(lat == (s_t + nbits_of(m)) * (1 << d) + 1, "R4/R5 latency", lat,
                  (s_t + nbits_of(m)) * (1 << d) + 1);
            check(smp == s_t * (1 << d), "R2 window", smp, s_t * (1 << d));
        end

        // R6: bus/2 source
        run_one(12'h5A5, 2'd1, 1'b0, 2'd1, 2'd0, lat, smp);
        check(lat == 2 * (SHORT + 10) + 1, "R6 half latency", lat, 2 * (SHORT + 10) + 1);
        check(result == exp_res(12'h5A5, 2'd1), "R6 half result", result, exp_res(12'h5A5, 2'd1));

        // R6: alternate source ticking every other cycle
        alt_run = 1'b1;
        run_one(12'h3C7, 2'd2, 1'b0, 2'd2, 2'd0, lat, smp);
        check(lat >= 2 * (SHORT + 12) && lat <= 2 * (SHORT + 12) + 3, "R6 alt latency",
              lat, 2 * (SHORT + 12));
        check(result == 12'h3C7, "R6 alt result", result, 12'h3C7);
        alt_run = 1'b0;

        // R6 R9: async source, continuous; warm-up only before the first
        async_tick = 1'b1;
        cont = 1'b1;
        run_one(12'h0F0, 2'd0, 1'b0, 2'd3, 2'd0, lat, smp);
        check(lat == WARM + SHORT + 8 + 1, "R6 async latency", lat, WARM + SHORT + 8 + 1);
        check(result == 12'h00F, "R6 async result", result, 12'h00F);
        vin = 12'hE1F;
        next_done(gap);
        check(gap == SHORT + 8, "R9 continuous gap", gap, SHORT + 8);
        check(result == 12'h0E1, "R9 second result", result, 12'h0E1);
        cont = 1'b0;
        vin = 12'h777;
        next_done(gap);
        check(gap == SHORT + 8 && result == 12'h077, "R9 last result", result, 12'h077);
        @(negedge clk);
        check(!busy, "R9 idle after cont drop", busy, 0);
        async_tick = 1'b0;

        // R8: read strobe while idle clears the flag, result untouched
        held = result;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check(!done_flag && result == held, "R8 rd_ack clear", done_flag, 0);

        // R7 R8: start clears flag, result holds until completion
        run_one(12'h321, 2'd2, 1'b0, 2'd0, 2'd0, lat, smp);
        held = result;
        @(negedge clk);
        vin = 12'hC00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done_flag, "R8 start clear", done_flag, 0);
        repeat (8) @(negedge clk);
        check(result == held, "R7 result hold", result, held);

        // R10: abort mid-conversion and restart
        @(negedge clk);
        vin = 12'h456; start = 1'b1;
        lat = 0;
        early = 1'b0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done_flag && lat < SHORT + 12 + 1) early = 1'b1;
        end while (!done_flag && lat < 5000);
        check(!early && lat == SHORT + 12 + 1, "R10 restart latency", lat, SHORT + 12 + 1);
        check(result == 12'h456, "R10 restart result", result, 12'h456);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule